// File: doc/BRIEF.md
# Watchdog Timer with Grace-Delayed System Reset

This block watches for software that stops servicing it. An 18-bit up counter runs on the slow watchdog clock. When it reaches the selected interval it sets a sticky time-out flag, which drives an interrupt when that is enabled. If the slow clock comes from the 32 kHz source and wake-up is enabled, it also sets a sticky wake flag. The time-out then opens a grace window of programmable length. If software clears the counter inside that window, nothing further happens. If the window runs out, the block drives a system reset pulse of fixed length, provided reset is enabled.

A three-state machine orders the sequence. IDLE goes to GRACE on a time-out while reset is enabled. GRACE goes back to IDLE on a counter clear, when the watchdog is disabled, or when reset enable drops. GRACE goes to HOLD when the grace window expires. HOLD asserts the system reset and returns to IDLE after the hold count. The counter stays at zero during HOLD and restarts from zero once HOLD ends. A power-on strap input forces the watchdog on.

All control goes through one 13-bit register with a write strobe. The read data is always valid.

Register fields:
- [0] counter clear: write 1; always reads 0.
- [1] reset enable.
- [2] reset flag.
- [3] time-out flag.
- [4] wake enable.
- [5] wake flag.
- [6] interrupt enable.
- [7] watchdog enable: reads the effective enable.
- [10:8] interval select.
- [12:11] grace select.

Top module: `wdog_core`

## Requirements
- R1: After a counter clear with the watchdog enabled, the time-out flag (bit 3) sets exactly 2^(4+2*S) watchdog clocks later, where S is field [10:8] (000 gives 16, 001 gives 64, up to 111 giving 2^18).
- R2: After a time-out with reset enable (bit 1) high, the system reset asserts after a grace window of G clocks if the counter is not cleared. G depends on field [12:11]: 00 gives 1026, 01 gives 130, 10 gives 18 and 11 gives 3.
- R3: Once asserted, the system reset output stays high for exactly 63 watchdog clocks and then falls.
- R4: Writing 1 to bit 0 during the grace window cancels the pending reset and restarts the interval count from zero.
- R5: With reset enable low, a time-out still sets the flags but no system reset is ever driven.
- R6: The interrupt output is high exactly when both the time-out flag and interrupt enable (bit 6) are set.
- R7: The wake flag (bit 5) and the wake request output set on a time-out only when wake enable (bit 4) is high and the 32 kHz source indicator is high.
- R8: The reset, time-out and wake flags are sticky. Each is cleared by writing 1 to its own bit, and each survives the reset pulse that the block itself drives.
- R9: While the power-on strap is high, the watchdog counts and bit 7 reads 1, even if software writes 0 to bit 7.
- R10: After power reset, every register bit reads 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Power-on reset, active low |
| force_on | input | 1 | Strap that forces the watchdog enabled |
| src_is_32k | input | 1 | High when the watchdog clock is the 32 kHz source |
| reg_wr | input | 1 | Register write strobe |
| wr_data | input | 13 | Register write data |
| rd_data | output | 13 | Register read data |
| irq | output | 1 | Time-out interrupt |
| wake_req | output | 1 | Wake-up request to the power controller |
| sys_rst | output | 1 | System reset pulse, active high |

## Verification
The bench targets the exact cycle of the time-out and of the reset edges. A counter that compared against the wrong limit, or a grace table that was off by one, would move these edges by at least one clock. It cancels a pending reset late in the grace window. A design that did not restart the count would assert reset too early, and one that ignored the clear would assert reset at the first expiry. It also checks the gated cases: the wake flag set from a non-32 kHz clock, reset issued with reset enable low, and the strap ignored. Each of these shows up as a wrong output level or a wrong readback word. Finally, it reads the flags back after a reset pulse, which catches flags that the block's own reset wrongly clears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int REG_W = 13;

    localparam int B_CLR   = 0;
    localparam int B_RSTEN = 1;
    localparam int B_RSTF  = 2;
    localparam int B_TOF   = 3;
    localparam int B_WKEN  = 4;
    localparam int B_WKF   = 5;
    localparam int B_INTEN = 6;
    localparam int B_EN    = 7;
    localparam int B_SEL   = 8;
    localparam int B_DLY   = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRACE = 2'd1,
        ST_HOLD  = 2'd2
    } wd_state_e;

    function automatic int unsigned grace_len(input logic [1:0] code);
        unique case (code)
            2'b00:   return 1026;
            2'b01:   return 130;
            2'b10:   return 18;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       clr,
    input  logic       hold,
    input  logic [2:0] sel,
    output logic       timeout
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;

    always_comb begin
        span  = (CNT_W+1)'(1) << (4 + 2 * int'(sel));
        limit = CNT_W'(span - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || !enable || hold)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign timeout = enable && !hold && !clr && (cnt == limit);

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
#(
    parameter int HOLD_LEN = 63
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timeout,
    input  logic       clr,
    input  logic       enable,
    input  logic       rst_en,
    input  logic [1:0] dly,
    output logic       sys_rst,
    output logic       hold,
    output logic       rst_evt
);
    localparam int MAXL = (HOLD_LEN > 1026) ? HOLD_LEN : 1026;
    localparam int TW   = $clog2(MAXL + 1);

    wd_state_e       state, state_n;
    logic [TW-1:0]   tmr;
    logic [TW-1:0]   grace_last;

    assign grace_last = TW'(grace_len(dly) - 1);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (timeout && rst_en) state_n = ST_GRACE;
            ST_GRACE: begin
                if (clr || !enable || !rst_en) state_n = ST_IDLE;
                else if (tmr == grace_last)    state_n = ST_HOLD;
            end
            ST_HOLD:  if (tmr == TW'(HOLD_LEN - 1)) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_n;
            tmr   <= (state_n != state) ? '0 : tmr + 1'b1;
        end
    end

    always_comb begin
        sys_rst = (state == ST_HOLD);
        hold    = (state == ST_HOLD);
        rst_evt = (state == ST_GRACE) && (state_n == ST_HOLD);
    end

    p_grace_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && $past(state) == ST_IDLE) |-> $past(timeout));
    p_hold_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |=> sys_rst);
    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRACE && clr) |=> (state == ST_IDLE));
    p_no_rst_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(rst_en));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 18,
    parameter int HOLD_LEN = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_on,
    input  logic             src_is_32k,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             wake_req,
    output logic             sys_rst
);
    logic       en_q, rsten_q, wken_q, inten_q;
    logic [2:0] sel_q;
    logic [1:0] dly_q;
    logic       f_to, f_wk, f_rst;
    logic       enable, clr, timeout, hold, rst_evt;

    assign enable = en_q | force_on;
    assign clr    = reg_wr & wr_data[B_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rsten_q <= 1'b0;
            wken_q  <= 1'b0;
            inten_q <= 1'b0;
            sel_q   <= '0;
            dly_q   <= '0;
        end else if (reg_wr) begin
            en_q    <= wr_data[B_EN];
            rsten_q <= wr_data[B_RSTEN];
            wken_q  <= wr_data[B_WKEN];
            inten_q <= wr_data[B_INTEN];
            sel_q   <= wr_data[B_SEL +: 3];
            dly_q   <= wr_data[B_DLY +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_to  <= 1'b0;
            f_wk  <= 1'b0;
            f_rst <= 1'b0;
        end else begin
            f_to  <= (f_to  & ~(reg_wr & wr_data[B_TOF]))  | timeout;
            f_wk  <= (f_wk  & ~(reg_wr & wr_data[B_WKF]))  | (timeout & wken_q & src_is_32k);
            f_rst <= (f_rst & ~(reg_wr & wr_data[B_RSTF])) | rst_evt;
        end
    end

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .clr     (clr),
        .hold    (hold),
        .sel     (sel_q),
        .timeout (timeout)
    );

    wdog_seq #(.HOLD_LEN(HOLD_LEN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .timeout (timeout),
        .clr     (clr),
        .enable  (enable),
        .rst_en  (rsten_q),
        .dly     (dly_q),
        .sys_rst (sys_rst),
        .hold    (hold),
        .rst_evt (rst_evt)
    );

    always_comb begin
        rd_data            = '0;
        rd_data[B_RSTEN]   = rsten_q;
        rd_data[B_RSTF]    = f_rst;
        rd_data[B_TOF]     = f_to;
        rd_data[B_WKEN]    = wken_q;
        rd_data[B_WKF]     = f_wk;
        rd_data[B_INTEN]   = inten_q;
        rd_data[B_EN]      = enable;
        rd_data[B_SEL +: 3] = sel_q;
        rd_data[B_DLY +: 2] = dly_q;
        irq                = f_to & inten_q;
        wake_req           = f_wk;
    end

    p_flag_from_timeout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_to) |-> $past(timeout));
    p_wake_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_wk) |-> $past(src_is_32k && wken_q));
    p_rst_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_rst) |-> sys_rst);

endmodule

// File: tb/sim_wdog_core.sv
module sim_wdog_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        force_on = 1'b0;
    logic        src_is_32k = 1'b0;
    logic        reg_wr = 1'b0;
    logic [12:0] wr_data = '0;
    logic [12:0] rd_data;
    logic        irq, wake_req, sys_rst;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int          at;
        int          which;
        logic [12:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;

    always #4 clk = ~clk;

    wdog_core u0 (
        .clk(clk), .rst_n(rst_n), .force_on(force_on), .src_is_32k(src_is_32k),
        .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .wake_req(wake_req), .sys_rst(sys_rst)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [12:0] pick(input int which);
        case (which)
            0:       return {12'd0, irq};
            1:       return {12'd0, wake_req};
            2:       return {12'd0, sys_rst};
            default: return rd_data;
        endcase
    endfunction

    // monitor: pops expectations whose cycle has come
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            cur = q.pop_front();
            n_cmp++;
            if (cur.at < cyc) begin
                n_bad++;
                $display("FAIL %s: stale item for cycle %0d at cycle %0d", cur.tag, cur.at, cyc);
            end else if (pick(cur.which) !== cur.val) begin
                n_bad++;
                $display("FAIL %s: cycle %0d sig %0d actual %h expected %h",
                         cur.tag, cyc, cur.which, pick(cur.which), cur.val);
            end
        end
    end

    task automatic push(input int at, input int which, input logic [12:0] v, input string tag);
        exp_t e;
        e.at = at; e.which = which; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr_reg(input logic [12:0] d, output int w);
        @(negedge clk);
        reg_wr  = 1'b1;
        wr_data = d;
        w = cyc + 1;
        @(negedge clk);
        reg_wr  = 1'b0;
        wr_data = '0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic por(input logic strap, input logic s32);
        @(negedge clk);
        rst_n = 1'b0;
        force_on = strap;
        src_is_32k = s32;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: bench timed out");
        finish_run();
    end

    initial begin
        int w, w2;

        // R10: reset state
        por(1'b0, 1'b1);
        push(cyc + 1, 3, 13'h0000, "R10");
        push(cyc + 1, 0, 1'b0, "R10");
        push(cyc + 1, 1, 1'b0, "R10");
        push(cyc + 1, 2, 1'b0, "R10");
        drain();

        // R1 R2 R3 R6 R7 R8: interval 16, grace 3, all enables
        wr_reg(13'h18D3, w);
        push(w + 15, 0, 1'b0, "R1 irq before");
        push(w + 16, 0, 1'b1, "R1 R6 irq at interval");
        push(w + 16, 1, 1'b1, "R7 wake");
        push(w + 18, 2, 1'b0, "R2 no reset yet");
        push(w + 19, 2, 1'b1, "R2 reset at grace end");
        push(w + 81, 2, 1'b1, "R3 reset last cycle");
        push(w + 82, 2, 1'b0, "R3 reset fell");
        push(w + 85, 3, 13'h18FE, "R8 flags survive");
        drain();

        // R8: write-1-clear of the flags
        wr_reg(13'h002C, w);
        push(w + 1, 3, 13'h0000, "R8 w1c");
        push(w + 1, 0, 1'b0, "R8 irq cleared");
        drain();

        // R4: clear late in a 130-clock grace window
        por(1'b0, 1'b1);
        wr_reg(13'h08C3, w);
        repeat (60) @(negedge clk);
        wr_reg(13'h08C3, w2);
        push(w2 + 1, 0, 1'b1, "R4 flag kept");
        push(w2 + 145, 2, 1'b0, "R4 reset cancelled");
        push(w2 + 146, 2, 1'b1, "R4 restart from zero");
        drain();

        // R5 R6: reset disabled, then clear flag
        por(1'b0, 1'b1);
        wr_reg(13'h18C1, w);
        push(w + 16, 0, 1'b1, "R6 irq");
        push(w + 19, 2, 1'b0, "R5 no reset");
        push(w + 40, 2, 1'b0, "R5 no reset later");
        push(w + 40, 3, 13'h18C8, "R5 flag set, reset flag clear");
        drain();
        wr_reg(13'h0048, w);
        push(w + 1, 0, 1'b0, "R6 irq after clear");
        push(w + 1, 3, 13'h0040, "R8 readback after clear");
        drain();

        // R6 R7: interrupt masked, wake gated by clock source
        por(1'b0, 1'b0);
        wr_reg(13'h0091, w);
        push(w + 17, 0, 1'b0, "R6 masked");
        push(w + 17, 1, 1'b0, "R7 gated");
        push(w + 17, 3, 13'h0098, "R7 flag only time-out");
        drain();

        // R9: strap forces enable
        por(1'b1, 1'b1);
        wr_reg(13'h0041, w);
        push(w + 15, 0, 1'b0, "R9 before");
        push(w + 16, 0, 1'b1, "R9 forced count");
        push(w + 16, 3, 13'h00C8, "R9 enable reads 1");
        drain();

        // R1 R2: interval 64, grace 18
        por(1'b0, 1'b1);
        wr_reg(13'h11C3, w);
        push(w + 63, 0, 1'b0, "R1 64 before");
        push(w + 64, 0, 1'b1, "R1 64 at");
        push(w + 81, 2, 1'b0, "R2 18 before");
        push(w + 82, 2, 1'b1, "R2 18 at");
        push(w + 82, 3, 13'h11CE, "R8 reset flag");
        drain();

        finish_run();
    end
endmodule